// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware side of entering an interrupt handler on a small processor with a 20-bit program counter, a 16-bit flag word and a 16-bit stack pointer. Once a request has been accepted, it runs a fixed 20-cycle program on a byte-wide memory bus. It reads the source descriptor, clears the control flags, pushes the old flags and PC, raises the priority field, and loads the handler address from a three-byte vector.

The surrounding core raises `intReq` at an instruction boundary, or when it suspends a long block or string instruction. With the request it presents its current flags, PC and stack pointer, plus whether the entry is a software trap and the trap's number. The block latches these values on the accepting edge. It ignores further requests until the sequence has finished. In the final cycle it presents the new flags, stack pointer and PC together with a one-cycle `done` pulse.

Top module: `irqEntrySeq`

## Requirements
- R1: While reset is held, `flagsOut`, `pcOut` and `spOut` are zero, and `busRd`, `busWr`, `srcClear` and `done` are low.
- R2: Cycle numbering starts at the edge where `intReq` is sampled high while idle; the next cycle is cycle 0. In cycle 0 the block reads address `INFO_ADDR` with `srcClear` high. It takes the level from bits [7:5] of the returned byte and the hardware source number from bits [4:0].
- R3: From cycle 2 on, `flagsOut` equals the flags latched at acceptance, with bit 4 (interrupt enable), bit 5 (single step) and bit 7 (stack select) cleared.
- R4: When the entry is a software trap whose number is 32 to 63 (`swNum[5]` set), bit 7 keeps its latched value. All other entries clear it.
- R5: Stack bytes are written in cycles 3, 5, 7 and 9, at SP-2, SP-1, SP-4 and SP-3 in that order. The 16-bit stack arithmetic wraps, and the upper four address bits are zero. The data written are, in order: {PC[19:16], flags[15:12]}, flags[7:0], PC[7:0] and PC[15:8], using the pre-entry flags and PC.
- R6: From cycle 11 on, `flagsOut[14:12]` holds the level read in cycle 0, and `spOut` equals the latched stack pointer minus 4, modulo 2^16.
- R7: Vector bytes are read in cycles 12, 14 and 16 at V, V+1 and V+2, where V = `VEC_BASE` + 4·n. Here n is `swNum` for a software trap and the hardware source number otherwise.
- R8: In cycle 19, `pcOut` equals {third byte[3:0], second byte, first byte} and `done` is high. `done` is high in no other cycle, and `pcOut` changes only at the end of cycle 18.
- R9: In every cycle without a transfer, `busRd` and `busWr` are low and `busAddr` and `busWdata` are zero. `busRd` and `busWr` are never high together.
- R10: A request seen while a sequence runs is ignored. If `intReq` is still high in the idle cycle after `done`, the next sequence starts with its cycle 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intReq | input | 1 | Entry request, accepted only while idle |
| flagsIn | input | 16 | Flag word before entry |
| pcIn | input | 20 | PC to be saved |
| spIn | input | 16 | Stack pointer before entry |
| swTrap | input | 1 | Entry is a software trap |
| swNum | input | 6 | Software trap number |
| busRdata | input | 8 | Read data, valid in the same cycle as the read |
| busAddr | output | 20 | Bus address |
| busWdata | output | 8 | Bus write data |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| srcClear | output | 1 | Clear-pending strobe for the source being read |
| flagsOut | output | 16 | Flag word being built |
| pcOut | output | 20 | Handler PC |
| spOut | output | 16 | Stack pointer after pushes |
| done | output | 1 | Entry complete, new PC valid |

## Verification
Every result of this block has a fixed due cycle counted from the accepting edge. The descriptor read falls in cycle 0, the flag clear is visible from cycle 2, the pushes fall in cycles 3 to 9, and the new level and stack pointer appear in cycle 11. The vector reads fall in cycles 12 to 16, and the new PC and `done` appear in cycle 19. The bench steps a behavioural model on the same rising edges, keeping the cycle index, the latched inputs and the pending results. It compares every output to the model at each falling edge, so each value is checked in exactly the cycle it becomes due and in every cycle it must stay put.

// File: rtl/irqEntryPkg.sv
package irqEntryPkg;
  localparam int ADDR_W   = 20;
  localparam int FLAG_W   = 16;
  localparam int SEQ_LEN  = 20;
  localparam int STEP_W   = $clog2(SEQ_LEN);
  localparam int BIT_IEN  = 4;
  localparam int BIT_STEP = 5;
  localparam int BIT_STK  = 7;
  localparam int LVL_LO   = 12;
  localparam int LVL_W    = 3;

  // step schedule
  localparam int ST_INFO  = 0;
  localparam int ST_MOD   = 1;
  localparam int ST_PUSH0 = 3;
  localparam int ST_PUSH1 = 5;
  localparam int ST_PUSH2 = 7;
  localparam int ST_PUSH3 = 9;
  localparam int ST_LEVEL = 10;
  localparam int ST_VEC0  = 12;
  localparam int ST_VEC1  = 14;
  localparam int ST_VEC2  = 16;
  localparam int ST_LOAD  = 18;
  localparam int ST_DONE  = SEQ_LEN - 1;

  typedef struct packed {
    logic       accept;
    logic       rdInfo;
    logic       modFlags;
    logic       wrStk;
    logic [1:0] stkSel;   // 0:SP-2 1:SP-1 2:SP-4 3:SP-3
    logic       setLevel;
    logic       rdVec;
    logic [1:0] vecSel;
    logic       loadPc;
    logic       done;
  } seqStrobeT;
endpackage

// File: rtl/irqSeqCtrl.sv
module irqSeqCtrl
  import irqEntryPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      req,
  output seqStrobeT strb
);
  logic              busy;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      if (req) begin
        busy <= 1'b1;
        step <= '0;
      end
    end else if (step == STEP_W'(ST_DONE)) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  always_comb begin
    strb        = '0;
    strb.accept = !busy && req;
    if (busy) begin
      case (int'(step))
        ST_INFO:  strb.rdInfo   = 1'b1;
        ST_MOD:   strb.modFlags = 1'b1;
        ST_PUSH0: begin strb.wrStk = 1'b1; strb.stkSel = 2'd0; end
        ST_PUSH1: begin strb.wrStk = 1'b1; strb.stkSel = 2'd1; end
        ST_PUSH2: begin strb.wrStk = 1'b1; strb.stkSel = 2'd2; end
        ST_PUSH3: begin strb.wrStk = 1'b1; strb.stkSel = 2'd3; end
        ST_LEVEL: strb.setLevel = 1'b1;
        ST_VEC0:  begin strb.rdVec = 1'b1; strb.vecSel = 2'd0; end
        ST_VEC1:  begin strb.rdVec = 1'b1; strb.vecSel = 2'd1; end
        ST_VEC2:  begin strb.rdVec = 1'b1; strb.vecSel = 2'd2; end
        ST_LOAD:  strb.loadPc   = 1'b1;
        ST_DONE:  strb.done     = 1'b1;
        default:  ;
      endcase
    end
  end

  assert_info_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> strb.rdInfo);
  assert_done_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !busy);
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.done) |=> (busy && !strb.accept));
endmodule

// File: rtl/irqSeqDatapath.sv
module irqSeqDatapath
  import irqEntryPkg::*;
#(
  parameter int                SP_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 20'h0FE00,
  parameter logic [ADDR_W-1:0] INFO_ADDR = 20'h00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [SP_W-1:0]   spIn,
  input  logic              swTrap,
  input  logic [5:0]        swNum,
  input  logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              busRd,
  output logic              busWr,
  output logic              srcClear,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [SP_W-1:0]   spOut,
  output logic              done
);
  localparam int PAD_W = ADDR_W - SP_W;

  logic [FLAG_W-1:0] tmpFlags;
  logic [ADDR_W-1:0] pcLat;
  logic [SP_W-1:0]   spLat;
  logic              trapLat;
  logic [5:0]        trapNum;
  logic [LVL_W-1:0]  level;
  logic [5:0]        vecNum;
  logic [7:0]        vb0, vb1;
  logic [3:0]        vb2;
  logic [ADDR_W-1:0] vecAddr;
  logic [SP_W-1:0]   stkAddr;
  logic [FLAG_W-1:0] clearedFlags;
  logic              keepStk;

  // latch entry context
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmpFlags <= '0;
      pcLat    <= '0;
      spLat    <= '0;
      trapLat  <= 1'b0;
      trapNum  <= '0;
    end else if (strb.accept) begin
      tmpFlags <= flagsIn;
      pcLat    <= pcIn;
      spLat    <= spIn;
      trapLat  <= swTrap;
      trapNum  <= swNum;
    end
  end

  // descriptor capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      level  <= '0;
      vecNum <= '0;
    end else if (strb.rdInfo) begin
      level  <= busRdata[7:5];
      vecNum <= trapLat ? trapNum : {1'b0, busRdata[4:0]};
    end
  end

  assign keepStk = trapLat && trapNum[5];

  always_comb begin
    clearedFlags           = tmpFlags;
    clearedFlags[BIT_IEN]  = 1'b0;
    clearedFlags[BIT_STEP] = 1'b0;
    if (!keepStk) clearedFlags[BIT_STK] = 1'b0;
  end

  // flag and stack pointer results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsOut <= '0;
      spOut    <= '0;
    end else if (strb.modFlags) begin
      flagsOut <= clearedFlags;
    end else if (strb.setLevel) begin
      flagsOut[LVL_LO +: LVL_W] <= level;
      spOut <= spLat - SP_W'(4);
    end
  end

  // vector byte capture and PC load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vb0   <= '0;
      vb1   <= '0;
      vb2   <= '0;
      pcOut <= '0;
    end else begin
      if (strb.rdVec) begin
        case (strb.vecSel)
          2'd0:    vb0 <= busRdata;
          2'd1:    vb1 <= busRdata;
          default: vb2 <= busRdata[3:0];
        endcase
      end
      if (strb.loadPc) pcOut <= {vb2, vb1, vb0};
    end
  end

  assign vecAddr = VEC_BASE + ADDR_W'({vecNum, 2'b00});

  always_comb begin
    case (strb.stkSel)
      2'd0:    stkAddr = spLat - SP_W'(2);
      2'd1:    stkAddr = spLat - SP_W'(1);
      2'd2:    stkAddr = spLat - SP_W'(4);
      default: stkAddr = spLat - SP_W'(3);
    endcase
  end

  // bus drive
  always_comb begin
    busAddr  = '0;
    busWdata = '0;
    if (strb.rdInfo) begin
      busAddr = INFO_ADDR;
    end else if (strb.rdVec) begin
      busAddr = vecAddr + ADDR_W'(strb.vecSel);
    end else if (strb.wrStk) begin
      busAddr = {{PAD_W{1'b0}}, stkAddr};
      case (strb.stkSel)
        2'd0:    busWdata = {pcLat[19:16], tmpFlags[15:12]};
        2'd1:    busWdata = tmpFlags[7:0];
        2'd2:    busWdata = pcLat[7:0];
        default: busWdata = pcLat[15:8];
      endcase
    end
  end

  assign busRd    = strb.rdInfo | strb.rdVec;
  assign busWr    = strb.wrStk;
  assign srcClear = strb.rdInfo;
  assign done     = strb.done;

  assert_bus_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));
  assert_stack_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (busAddr[ADDR_W-1:SP_W] == '0));
  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.modFlags || strb.setLevel) |=> $stable(flagsOut));
  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadPc |=> $stable(pcOut));
  assert_sp_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLevel |=> (spOut == $past(spLat) - SP_W'(4)));
endmodule

// File: rtl/irqEntrySeq.sv
module irqEntrySeq
  import irqEntryPkg::*;
#(
  parameter int                SP_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE  = 20'h0FE00,
  parameter logic [ADDR_W-1:0] INFO_ADDR = 20'h00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [SP_W-1:0]   spIn,
  input  logic              swTrap,
  input  logic [5:0]        swNum,
  input  logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  output logic              busRd,
  output logic              busWr,
  output logic              srcClear,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [SP_W-1:0]   spOut,
  output logic              done
);
  seqStrobeT strb;

  irqSeqCtrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .req  (intReq),
    .strb (strb)
  );

  irqSeqDatapath #(
    .SP_W      (SP_W),
    .VEC_BASE  (VEC_BASE),
    .INFO_ADDR (INFO_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .flagsIn  (flagsIn),
    .pcIn     (pcIn),
    .spIn     (spIn),
    .swTrap   (swTrap),
    .swNum    (swNum),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRd    (busRd),
    .busWr    (busWr),
    .srcClear (srcClear),
    .flagsOut (flagsOut),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .done     (done)
  );
endmodule

// File: tb/sim_irqEntrySeq.sv
module sim_irqEntrySeq;
  localparam logic [19:0] VBASE = 20'h0FE00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intReq = 1'b0;
  logic [15:0] flagsIn = '0;
  logic [19:0] pcIn = '0;
  logic [15:0] spIn = '0;
  logic        swTrap = 1'b0;
  logic [5:0]  swNum = '0;
  logic [7:0]  infoByte = '0;
  logic [7:0]  busRdata;
  logic [19:0] busAddr;
  logic [7:0]  busWdata;
  logic        busRd, busWr, srcClear, done;
  logic [15:0] flagsOut;
  logic [19:0] pcOut;
  logic [15:0] spOut;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  irqEntrySeq u0 (
    .clk(clk), .rstN(rstN), .intReq(intReq), .flagsIn(flagsIn), .pcIn(pcIn),
    .spIn(spIn), .swTrap(swTrap), .swNum(swNum), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busRd(busRd), .busWr(busWr),
    .srcClear(srcClear), .flagsOut(flagsOut), .pcOut(pcOut), .spOut(spOut),
    .done(done)
  );

  function automatic logic [7:0] memByte(input logic [19:0] a);
    if (a == 20'h0) return infoByte;
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  always_comb busRdata = memByte(busAddr);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          mBusy;
  int          mK;
  logic [15:0] mTmp, mFlags, mSp, mSpL;
  logic [19:0] mPcL, mPc;
  logic        mTrap;
  logic [5:0]  mTrapNum, mNum;
  logic [2:0]  mLevel;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mK = 0; mFlags = '0; mPc = '0; mSp = '0;
    end else if (mBusy) begin
      if (mK == 0) begin
        mLevel = infoByte[7:5];
        mNum   = mTrap ? mTrapNum : {1'b0, infoByte[4:0]};
      end
      if (mK == 1) begin
        mFlags = mTmp;
        mFlags[4] = 1'b0;
        mFlags[5] = 1'b0;
        if (!(mTrap && mTrapNum >= 6'd32)) mFlags[7] = 1'b0;
      end
      if (mK == 10) begin
        mFlags[14:12] = mLevel;
        mSp = mSpL - 16'd4;
      end
      if (mK == 18) begin
        logic [19:0] v;
        v = VBASE + 20'(int'(mNum) * 4);
        mPc = {memByte(v + 20'd2)[3:0], memByte(v + 20'd1), memByte(v)};
      end
      if (mK == 19) mBusy = 0; else mK++;
    end else if (intReq) begin
      mBusy = 1; mK = 0;
      mTmp = flagsIn; mPcL = pcIn; mSpL = spIn; mTrap = swTrap; mTrapNum = swNum;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic        eRd, eWr, eClr;
      logic [19:0] eAddr, v;
      logic [7:0]  eWd;
      eRd = 0; eWr = 0; eClr = 0; eAddr = '0; eWd = '0;
      v = VBASE + 20'(int'(mNum) * 4);
      if (mBusy) begin
        case (mK)
          0:  begin eRd = 1; eClr = 1; eAddr = 20'h0; end
          3:  begin eWr = 1; eAddr = {4'h0, mSpL - 16'd2}; eWd = {mPcL[19:16], mTmp[15:12]}; end
          5:  begin eWr = 1; eAddr = {4'h0, mSpL - 16'd1}; eWd = mTmp[7:0]; end
          7:  begin eWr = 1; eAddr = {4'h0, mSpL - 16'd4}; eWd = mPcL[7:0]; end
          9:  begin eWr = 1; eAddr = {4'h0, mSpL - 16'd3}; eWd = mPcL[15:8]; end
          12: begin eRd = 1; eAddr = v; end
          14: begin eRd = 1; eAddr = v + 20'd1; end
          16: begin eRd = 1; eAddr = v + 20'd2; end
          default: ;
        endcase
      end
      chk("R2 R7 R9 R10", "busRd", 32'(busRd), 32'(eRd));
      chk("R5 R9 R10", "busWr", 32'(busWr), 32'(eWr));
      chk("R2", "srcClear", 32'(srcClear), 32'(eClr));
      chk("R2 R5 R7 R9", "busAddr", 32'(busAddr), 32'(eAddr));
      chk("R5 R9", "busWdata", 32'(busWdata), 32'(eWd));
      chk("R3 R4 R6", "flagsOut", 32'(flagsOut), 32'(mFlags));
      chk("R6", "spOut", 32'(spOut), 32'(mSp));
      chk("R8", "pcOut", 32'(pcOut), 32'(mPc));
      chk("R8 R10", "done", 32'(done), 32'(mBusy && mK == 19));
    end
  end

  task automatic startEntry(input logic [15:0] f, input logic [19:0] pc,
                            input logic [15:0] sp, input logic trap,
                            input logic [5:0] num, input logic [7:0] info);
    @(negedge clk); #1;
    flagsIn = f; pcIn = pc; spIn = sp; swTrap = trap; swNum = num; infoByte = info;
    intReq = 1'b1;
    @(negedge clk); #1;
    intReq = 1'b0;
    flagsIn = ~f; pcIn = ~pc; spIn = ~sp; swTrap = ~trap;  // must not matter after accept
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired, run hung");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "flagsOut", 32'(flagsOut), 32'h0);
    chk("R1", "pcOut", 32'(pcOut), 32'h0);
    chk("R1", "spOut", 32'(spOut), 32'h0);
    chk("R1", "busRd|busWr", 32'(busRd | busWr), 32'h0);
    chk("R1", "srcClear|done", 32'(srcClear | done), 32'h0);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);

    // hardware entry, all flags set: R3 clears bit7 too
    startEntry(16'hFFFF, 20'hABCDE, 16'h1000, 1'b0, 6'd0, 8'hA7);
    repeat (22) @(negedge clk);
    // software trap 45 keeps stack-select bit (R4)
    startEntry(16'h70F0, 20'h12345, 16'h8000, 1'b1, 6'd45, 8'h43);
    repeat (22) @(negedge clk);
    // software trap 12 clears stack-select bit (R4)
    startEntry(16'h00B0, 20'hF0F0F, 16'h4321, 1'b1, 6'd12, 8'h20);
    repeat (22) @(negedge clk);
    // stack wrap and highest hardware number (R5 R6 R7)
    startEntry(16'h5A5A, 20'h00001, 16'h0002, 1'b0, 6'd63, 8'hFF);
    repeat (22) @(negedge clk);
    // R10: short pulse during a sequence is ignored
    startEntry(16'h0080, 20'h55555, 16'h0100, 1'b1, 6'd32, 8'h00);
    repeat (4) @(negedge clk);
    #1 intReq = 1'b1;
    @(negedge clk); #1 intReq = 1'b0;
    repeat (25) @(negedge clk);
    // R10: held request gives back-to-back sequences
    #1;
    flagsIn = 16'h0FF0; pcIn = 20'h9ABCD; spIn = 16'hFFFF; swTrap = 1'b0; infoByte = 8'h6B;
    intReq = 1'b1;
    repeat (30) @(negedge clk);
    #1 flagsIn = 16'hC3C3; pcIn = 20'h00F00;
    repeat (20) @(negedge clk);
    #1 intReq = 1'b0;
    repeat (25) @(negedge clk);
    finishRun();
  end
endmodule